// File: doc/BRIEF.md
# Multichannel Serial Port with Companding

A synchronous serial port with a transmit and a receive section. It generates its own serial clock and frame sync from the system clock and shifts words of 3 to 16 bits, most significant bit first. Transmit and receive share one bit timing, so the same clock and frame sync pace both sections.

Either section can work on single words through a parallel register, or on a circular buffer in external memory through a simple request interface. In buffer mode the block fetches or stores one word per serial word and interrupts once per full buffer. Companding with G.711 mu-law or A-law can be switched in: outgoing linear samples are compressed to 8-bit codes and incoming codes are expanded to left-aligned linear values.

A time-division-multiplexed mode runs a frame of 24 or 32 slots. Frame sync marks only slot 0, and two 32-bit select masks choose which slots are transmitted and which are received.

Top module: `sport_tdm`

## Requirements
- R1: A word is `word_len_m1`+1 bits long (values 2 to 15). Transmission sends the low `word_len_m1`+1 bits of the word, most significant of them first.
- R2: The serial clock `sclk` idles high while `en` is low. It has a period of 2×(`clk_div`+1) system clocks. `sdout` changes only when `sclk` falls, and `sdin` is sampled when `sclk` rises.
- R3: Without companding, a received word appears in `rx_word` right-justified, with every bit above the word length zero.
- R4: `fsync` is high during the first bit of a word. Outside TDM mode it marks every word. In TDM mode it marks only the first bit of slot 0.
- R5: `comp_mode`=2 selects mu-law and forces 8-bit words. A 16-bit linear sample is sent as its 8-bit code (0x7FFF→0x80, 0x0100→0xE7, 0xFFFF→0x7E). A received code is expanded to a 14-bit value left-aligned in 16 bits (0x80→0x7D7C, 0xE7→0x0104, 0x7E→0xFFF8).
- R6: `comp_mode`=3 selects A-law and forces 8-bit words. Sample codes: 0x7FFF→0xAA, 0x0000→0xD5, 0xFFFF→0x55. Received codes expand to 13-bit values left-aligned in 16 bits: 0xAA→0x7E00, 0xD5→0x0008, 0x55→0xFFF8. `comp_mode` values 0 and 1 disable companding.
- R7: With `tdm_en` high, a frame has 24 slots (`tdm_32`=0) or 32 slots (`tdm_32`=1). Bit s of `tx_sel` selects slot s for transmit. `sdout_oe` is high only during selected slots, and bits of `tx_sel` beyond the frame length have no effect.
- R8: In TDM mode only slots whose `rx_sel` bit is set update `rx_word` and raise `rx_irq`.
- R9: Without buffer mode, `tx_irq` pulses for one cycle at the end of each transmitted selected word, and `rx_irq` pulses for each received selected word.
- R10: In buffer mode, fetches read `ab_tx_base`+offset and stores write `ab_rx_base`+offset. The offset starts at 0 on enable and advances by `ab_step` modulo `ab_len` (`ab_step` < `ab_len`).
- R11: In buffer mode, `tx_irq` and `rx_irq` each pulse once per `ab_len` words. Every received word is stored through `ab_rx_req`, `ab_rx_addr` and `ab_rx_wdata`.
- R12: When `en` goes high, bit timing starts afresh, and the first word after enable belongs to slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| en | input | 1 | Port run enable |
| clk_div | input | DIVW | Serial clock divisor |
| word_len_m1 | input | 4 | Word length minus one |
| comp_mode | input | 2 | 0/1 off, 2 mu-law, 3 A-law |
| tdm_en | input | 1 | TDM mode enable |
| tdm_32 | input | 1 | 32 slots when set, else 24 |
| tx_sel | input | 32 | Transmit slot select mask |
| rx_sel | input | 32 | Receive slot select mask |
| tx_wr | input | 1 | Write strobe for transmit word |
| tx_wdata | input | 16 | Transmit word |
| rx_word | output | 16 | Last received word |
| tx_irq | output | 1 | Transmit completion pulse |
| rx_irq | output | 1 | Receive completion pulse |
| sclk | output | 1 | Serial clock |
| fsync | output | 1 | Frame sync |
| sdout | output | 1 | Serial data out |
| sdout_oe | output | 1 | Data out drive enable |
| sdin | input | 1 | Serial data in |
| ab_en | input | 1 | Buffer mode enable |
| ab_tx_base | input | AW | Transmit buffer base |
| ab_rx_base | input | AW | Receive buffer base |
| ab_len | input | AW | Buffer length in words |
| ab_step | input | AW | Offset step |
| ab_tx_req | output | 1 | Fetch strobe |
| ab_tx_addr | output | AW | Fetch address |
| ab_tx_rdata | input | 16 | Fetched word, same cycle |
| ab_rx_req | output | 1 | Store strobe |
| ab_rx_addr | output | AW | Store address |
| ab_rx_wdata | output | 16 | Stored word |

## Verification
The hardest situation to reach from the ports is a TDM frame in which one slot is received but not transmitted. That slot must capture an undriven line, while the masks and interrupts stay aligned to the right slots. The bench loops `sdout` back to `sdin`, gated by `sdout_oe`. It starts the port from idle so the first frame begins at slot 0, and uses masks that include an out-of-frame bit. It then walks one frame bit by bit and counts interrupts between two frame syncs. Buffer wrap with a step that is not 1 is reached by answering fetches from a small table and following the stored addresses.

// File: rtl/sport_tdm.sv
module sport_tdm #(
  parameter int DIVW = 16,
  parameter int AW   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [DIVW-1:0] clk_div,
  input  logic [3:0]      word_len_m1,
  input  logic [1:0]      comp_mode,
  input  logic            tdm_en,
  input  logic            tdm_32,
  input  logic [31:0]     tx_sel,
  input  logic [31:0]     rx_sel,
  input  logic            tx_wr,
  input  logic [15:0]     tx_wdata,
  output logic [15:0]     rx_word,
  output logic            tx_irq,
  output logic            rx_irq,
  output logic            sclk,
  output logic            fsync,
  output logic            sdout,
  output logic            sdout_oe,
  input  logic            sdin,
  input  logic            ab_en,
  input  logic [AW-1:0]   ab_tx_base,
  input  logic [AW-1:0]   ab_rx_base,
  input  logic [AW-1:0]   ab_len,
  input  logic [AW-1:0]   ab_step,
  output logic            ab_tx_req,
  output logic [AW-1:0]   ab_tx_addr,
  input  logic [15:0]     ab_tx_rdata,
  output logic            ab_rx_req,
  output logic [AW-1:0]   ab_rx_addr,
  output logic [15:0]     ab_rx_wdata
);

  function automatic logic [7:0] mu_enc(input logic [15:0] x);
    logic [13:0] m, b;
    logic [3:0]  p, d;
    logic [2:0]  seg;
    logic [3:0]  mant;
    m = x[15] ? (~x[15:2] + 14'd1) : x[15:2];
    if (m > 14'd8159) m = 14'd8159;
    b = m + 14'd33;
    p = 4'd5;
    for (int i = 5; i < 14; i++) if (b[i]) p = 4'(i);
    d = p - 4'd5;
    if (p == 4'd13) begin seg = 3'd7; mant = 4'hF; end
    else begin seg = d[2:0]; mant = 4'(b >> (p - 4'd4)); end
    return {~x[15], ~seg, ~mant};
  endfunction

  function automatic logic [7:0] a_enc(input logic [15:0] x);
    logic [11:0] m;
    logic [3:0]  p, d;
    logic [3:0]  mant;
    m = x[15] ? ~x[14:3] : x[14:3];
    p = 4'd4;
    for (int i = 5; i < 12; i++) if (m[i]) p = 4'(i);
    d = p - 4'd4;
    mant = (d < 4'd2) ? m[4:1] : 4'(m >> d);
    return {~x[15], d[2:0] ^ 3'b101, mant ^ 4'b0101};
  endfunction

  function automatic logic [15:0] mu_dec(input logic [7:0] c);
    logic [7:0]  u;
    logic [15:0] t;
    u = ~c;
    t = ({9'd0, u[3:0], 3'd0} + 16'h0084) << u[6:4];
    return u[7] ? (16'h0084 - t) : (t - 16'h0084);
  endfunction

  function automatic logic [15:0] a_dec(input logic [7:0] c);
    logic [7:0]  a;
    logic [15:0] t;
    a = c ^ 8'h55;
    t = {8'd0, a[3:0], 4'd0};
    if (a[6:4] == 3'd0) t = t + 16'd8;
    else t = (t + 16'h0108) << (a[6:4] - 3'd1);
    return a[7] ? t : (16'd0 - t);
  endfunction

  function automatic logic [AW-1:0] wrap_add(input logic [AW-1:0] o, s, l);
    logic [AW:0] t;
    t = {1'b0, o} + {1'b0, s};
    if (t >= {1'b0, l}) t = t - {1'b0, l};
    return t[AW-1:0];
  endfunction

  logic [DIVW-1:0] dcnt;
  logic [3:0]      bit_i;
  logic [4:0]      slot;
  logic            live, oe;
  logic [15:0]     tx_hold, txsh, rxsh;
  logic [AW-1:0]   tofs, tcnt, rofs, rcnt;

  wire        companding = comp_mode[1];
  wire [3:0]  wl        = companding ? 4'd7 : word_len_m1;
  wire [4:0]  last_slot = tdm_32 ? 5'd31 : 5'd23;
  wire        tick      = en && (dcnt == clk_div);
  wire        fall      = tick && sclk;
  wire        rise      = tick && !sclk;
  wire        word_end  = !live || (bit_i == wl);
  wire [4:0]  nslot     = (!tdm_en || slot == last_slot) ? 5'd0 : slot + 5'd1;
  wire        tx_now    = !tdm_en || tx_sel[slot];
  wire        tx_next   = !tdm_en || tx_sel[nslot];
  wire        rx_now    = !tdm_en || rx_sel[slot];
  wire        fetch     = fall && word_end && tx_next && ab_en;
  wire [15:0] src       = ab_en ? ab_tx_rdata : tx_hold;
  wire [7:0]  code      = comp_mode[0] ? a_enc(src) : mu_enc(src);
  wire [15:0] txword    = companding ? {8'd0, code} : src;
  wire [15:0] rxbits    = {rxsh[14:0], sdin} & (16'hFFFF >> (4'd15 - wl));
  wire [15:0] rxval     = !companding ? rxbits :
                          comp_mode[0] ? a_dec(rxbits[7:0]) : mu_dec(rxbits[7:0]);

  assign sdout       = txsh[15];
  assign sdout_oe    = en && oe;
  assign ab_tx_req   = fetch;
  assign ab_tx_addr  = ab_tx_base + tofs;
  assign ab_rx_wdata = rx_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tx_hold <= '0;
    else if (tx_wr) tx_hold <= tx_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dcnt <= '0; sclk <= 1'b1; bit_i <= '0; slot <= '0; live <= 1'b0;
      oe <= 1'b0; fsync <= 1'b0; txsh <= '0; rxsh <= '0; rx_word <= '0;
      tx_irq <= 1'b0; rx_irq <= 1'b0; ab_rx_req <= 1'b0; ab_rx_addr <= '0;
      tofs <= '0; tcnt <= '0; rofs <= '0; rcnt <= '0;
    end else begin
      tx_irq <= 1'b0; rx_irq <= 1'b0; ab_rx_req <= 1'b0;
      if (!en) begin
        dcnt <= '0; sclk <= 1'b1; bit_i <= '0; slot <= last_slot; live <= 1'b0;
        oe <= 1'b0; fsync <= 1'b0;
        tofs <= '0; tcnt <= '0; rofs <= '0; rcnt <= '0;
      end else begin
        dcnt <= tick ? '0 : dcnt + 1'b1;
        if (tick) sclk <= !sclk;
        if (fall) begin
          if (word_end) begin
            bit_i <= '0;
            slot  <= nslot;
            live  <= 1'b1;
            txsh  <= txword << (4'd15 - wl);
            fsync <= !tdm_en || nslot == 5'd0;
            oe    <= tx_next;
            tx_irq <= ab_en ? (fetch && tcnt == ab_len - 1'b1) : (live && tx_now);
            if (fetch) begin
              tofs <= wrap_add(tofs, ab_step, ab_len);
              tcnt <= (tcnt == ab_len - 1'b1) ? '0 : tcnt + 1'b1;
            end
          end else begin
            bit_i <= bit_i + 4'd1;
            txsh  <= txsh << 1;
            fsync <= 1'b0;
          end
        end
        if (rise) begin
          rxsh <= {rxsh[14:0], sdin};
          if (live && bit_i == wl && rx_now) begin
            rx_word <= rxval;
            if (ab_en) begin
              ab_rx_req  <= 1'b1;
              ab_rx_addr <= ab_rx_base + rofs;
              rx_irq     <= (rcnt == ab_len - 1'b1);
              rofs <= wrap_add(rofs, ab_step, ab_len);
              rcnt <= (rcnt == ab_len - 1'b1) ? '0 : rcnt + 1'b1;
            end else begin
              rx_irq <= 1'b1;
            end
          end
        end
      end
    end
  end

  a_r2_sdout_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    en && $past(en) && !$fell(sclk) |-> $stable(sdout));

  a_r3_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq && !ab_en && !comp_mode[1] && word_len_m1 != 4'd15
      |-> (rx_word >> ({1'b0, word_len_m1} + 5'd1)) == 16'd0);

  a_r7_slot0_drive: assert property (@(posedge clk) disable iff (!rst_n)
    en && tdm_en && fsync |-> sdout_oe == tx_sel[0]);

  a_r10_fetch_in_buffer: assert property (@(posedge clk) disable iff (!rst_n)
    ab_tx_req |-> (ab_tx_addr - ab_tx_base) < ab_len);

  a_r10_store_in_buffer: assert property (@(posedge clk) disable iff (!rst_n)
    ab_rx_req |-> (ab_rx_addr - ab_rx_base) < ab_len);

  a_r11_irq_with_store: assert property (@(posedge clk) disable iff (!rst_n)
    ab_en && rx_irq |-> ab_rx_req);

endmodule

// File: tb/tb_sport_tdm.sv
`timescale 1ns/1ps
module tb_sport_tdm;
  localparam int AW = 8;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0;
  logic [15:0] clk_div = 16'd1;
  logic [3:0]  word_len_m1 = 4'd7;
  logic [1:0]  comp_mode = 2'd0;
  logic        tdm_en = 1'b0, tdm_32 = 1'b0;
  logic [31:0] tx_sel = '0, rx_sel = '0;
  logic        tx_wr = 1'b0;
  logic [15:0] tx_wdata = '0;
  logic [15:0] rx_word;
  logic        tx_irq, rx_irq, sclk, fsync, sdout, sdout_oe, sdin;
  logic        ab_en = 1'b0;
  logic [AW-1:0] ab_tx_base = 8'h10, ab_rx_base = 8'h40, ab_len = 8'd3, ab_step = 8'd2;
  logic        ab_tx_req, ab_rx_req;
  logic [AW-1:0] ab_tx_addr, ab_rx_addr;
  logic [15:0] ab_tx_rdata, ab_rx_wdata;

  always #5 clk = ~clk;

  assign sdin = sdout_oe & sdout;
  assign ab_tx_rdata = (ab_tx_addr == 8'h10) ? 16'h0011 :
                       (ab_tx_addr == 8'h11) ? 16'h0022 :
                       (ab_tx_addr == 8'h12) ? 16'h0033 : 16'hDEAD;

  sport_tdm dut (
    .clk(clk), .rst_n(rst_n), .en(en), .clk_div(clk_div), .word_len_m1(word_len_m1),
    .comp_mode(comp_mode), .tdm_en(tdm_en), .tdm_32(tdm_32), .tx_sel(tx_sel), .rx_sel(rx_sel),
    .tx_wr(tx_wr), .tx_wdata(tx_wdata), .rx_word(rx_word), .tx_irq(tx_irq), .rx_irq(rx_irq),
    .sclk(sclk), .fsync(fsync), .sdout(sdout), .sdout_oe(sdout_oe), .sdin(sdin),
    .ab_en(ab_en), .ab_tx_base(ab_tx_base), .ab_rx_base(ab_rx_base), .ab_len(ab_len),
    .ab_step(ab_step), .ab_tx_req(ab_tx_req), .ab_tx_addr(ab_tx_addr), .ab_tx_rdata(ab_tx_rdata),
    .ab_rx_req(ab_rx_req), .ab_rx_addr(ab_rx_addr), .ab_rx_wdata(ab_rx_wdata));

  int n_tests = 0, n_fail = 0;
  int n_txirq = 0, n_rxirq = 0;
  int mon_wl = 7;
  string cur_req = "R1";
  logic [15:0] ser_q[$];
  logic [15:0] rx_q[$];
  logic [23:0] ab_q[$];

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (tx_irq) n_txirq++;
    if (rx_irq) n_rxirq++;
    if (rx_irq && !ab_en && rx_q.size() > 0) begin
      logic [15:0] e;
      e = rx_q.pop_front();
      check(rx_word == e, cur_req, rx_word, e);
    end
    if (ab_rx_req && ab_q.size() > 0) begin
      logic [23:0] e;
      e = ab_q.pop_front();
      check({ab_rx_addr, ab_rx_wdata} == e, "R10 R11 store", {ab_rx_addr, ab_rx_wdata}, e);
    end
  end

  initial begin
    forever begin
      @(posedge sclk); #1;
      if (fsync && ser_q.size() > 0) begin
        logic [15:0] w, e;
        w = {15'd0, sdout};
        for (int i = 1; i <= mon_wl; i++) begin
          @(posedge sclk); #1;
          w = {w[14:0], sdout};
        end
        e = ser_q.pop_front();
        check(w == e, cur_req, w, e);
      end
    end
  end

  task automatic run_word(input string req, input logic [3:0] wl, input logic [1:0] cm,
                          input logic [15:0] txv, input logic [15:0] exp_ser, input logic [15:0] exp_rx);
    cur_req = req;
    word_len_m1 = wl; comp_mode = cm;
    mon_wl = cm[1] ? 7 : int'(wl);
    @(negedge clk); tx_wdata = txv; tx_wr = 1'b1;
    @(negedge clk); tx_wr = 1'b0;
    ser_q.push_back(exp_ser);
    rx_q.push_back(exp_rx);
    en = 1'b1;
    wait (ser_q.size() == 0 && rx_q.size() == 0);
    @(negedge clk); en = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    check(sclk == 1'b1, "R12 reset sclk", sclk, 1);
    check(fsync == 1'b0, "R12 reset fsync", fsync, 0);
    check(sdout_oe == 1'b0, "R12 reset oe", sdout_oe, 0);
    check(rx_word == 16'd0, "R12 reset rx_word", rx_word, 0);
    check(!tx_irq && !rx_irq, "R12 reset irq", {tx_irq, rx_irq}, 0);

    begin : period_r2
      time t0, t1;
      clk_div = 16'd3; en = 1'b1;
      @(posedge sclk); t0 = $time;
      @(posedge sclk); t1 = $time;
      check((t1 - t0) == 80, "R2 sclk period", 32'(t1 - t0), 80);
      @(negedge clk); en = 1'b0;
      repeat (4) @(negedge clk);
      check(sclk == 1'b1, "R2 idle high", sclk, 1);
      clk_div = 16'd1;
    end

    run_word("R1 8-bit", 4'd7, 2'd0, 16'h00A5, 16'h00A5, 16'h00A5);
    run_word("R1 R3 3-bit", 4'd2, 2'd0, 16'hFFFD, 16'h0005, 16'h0005);
    run_word("R1 R3 16-bit", 4'd15, 2'd0, 16'h8001, 16'h8001, 16'h8001);
    run_word("R5 mu max", 4'd3, 2'd2, 16'h7FFF, 16'h0080, 16'h7D7C);
    run_word("R5 mu 0x0100", 4'd3, 2'd2, 16'h0100, 16'h00E7, 16'h0104);
    run_word("R5 mu -1", 4'd3, 2'd2, 16'hFFFF, 16'h007E, 16'hFFF8);
    run_word("R6 A max", 4'd3, 2'd3, 16'h7FFF, 16'h00AA, 16'h7E00);
    run_word("R6 A zero", 4'd3, 2'd3, 16'h0000, 16'h00D5, 16'h0008);
    run_word("R6 A -1", 4'd3, 2'd3, 16'hFFFF, 16'h0055, 16'hFFF8);

    begin : tdm_r7_r8
      int fsc, tx0, rx0;
      cur_req = "R8 R12 tdm rx";
      word_len_m1 = 4'd7; comp_mode = 2'd0; mon_wl = 7;
      tdm_en = 1'b1; tdm_32 = 1'b0;
      tx_sel = (32'd1 << 5) | (32'd1 << 23) | (32'd1 << 30);
      rx_sel = (32'd1 << 5) | (32'd1 << 9) | (32'd1 << 12);
      @(negedge clk); tx_wdata = 16'h003C; tx_wr = 1'b1;
      @(negedge clk); tx_wr = 1'b0;
      rx_q.push_back(16'h003C); rx_q.push_back(16'h0000); rx_q.push_back(16'h0000);
      en = 1'b1;
      do begin @(posedge sclk); #1; end while (!fsync);
      tx0 = n_txirq; rx0 = n_rxirq; fsc = 0;
      for (int s = 0; s < 24; s++) begin
        for (int b = 0; b < 8; b++) begin
          if (s > 0 || b > 0) begin @(posedge sclk); #1; end
          if (b == 0) check(sdout_oe == tx_sel[s], "R7 slot drive", sdout_oe, tx_sel[s]);
          if (fsync) fsc++;
        end
      end
      check(fsc == 1, "R4 one sync per frame", fsc, 1);
      @(posedge sclk); #1;
      check(fsync == 1'b1, "R7 24-slot frame wrap", fsync, 1);
      check(n_txirq - tx0 == 2, "R9 tx irq per frame", n_txirq - tx0, 2);
      check(n_rxirq - rx0 == 3, "R8 R9 rx irq per frame", n_rxirq - rx0, 3);
      check(rx_q.size() == 0, "R8 rx scoreboard drained", rx_q.size(), 0);
      @(negedge clk); en = 1'b0;
      repeat (6) @(negedge clk);
    end

    begin : tdm32_r7
      int n;
      tdm_32 = 1'b1; en = 1'b1;
      do begin @(posedge sclk); #1; end while (!fsync);
      n = 0;
      do begin @(posedge sclk); #1; n++; end while (!fsync);
      check(n == 256, "R7 32-slot frame length", n, 256);
      @(negedge clk); en = 1'b0; tdm_en = 1'b0; tdm_32 = 1'b0;
      repeat (6) @(negedge clk);
    end

    begin : abuf_r10_r11
      cur_req = "R10 fetch order";
      clk_div = 16'd3; ab_en = 1'b1;
      ser_q.push_back(16'h11); ser_q.push_back(16'h33); ser_q.push_back(16'h22);
      ser_q.push_back(16'h11); ser_q.push_back(16'h33); ser_q.push_back(16'h22);
      ab_q.push_back({8'h40, 16'h11}); ab_q.push_back({8'h42, 16'h33}); ab_q.push_back({8'h41, 16'h22});
      ab_q.push_back({8'h40, 16'h11}); ab_q.push_back({8'h42, 16'h33}); ab_q.push_back({8'h41, 16'h22});
      @(negedge clk); n_txirq = 0; n_rxirq = 0; en = 1'b1;
      wait (ab_q.size() == 0);
      en = 1'b0;
      repeat (6) @(negedge clk);
      check(ser_q.size() == 0, "R10 all fetched words sent", ser_q.size(), 0);
      check(n_txirq == 2, "R11 tx irq per buffer", n_txirq, 2);
      check(n_rxirq == 2, "R11 rx irq per buffer", n_rxirq, 2);
      ab_en = 1'b0;
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule